// File: doc/BRIEF.md
# Seconds Real-Time Clock with Match Alarm

This peripheral keeps wall-clock time as a 32-bit count of seconds. A prescaler divides the system clock down to one tick per second, and each tick advances the count. Software can load the count with any value, and it can program a 32-bit match value. When the count reaches the match value, the block raises an alarm.

The alarm state is a single flag. It is driven out as a level and, at each setting event, as a one-cycle pulse. A single register offset serves two purposes. Reading it returns the flag. Writing it either clears the flag or forces it on.

A second, relative counter reports how many seconds have passed since software last restarted it. Two constant identification words sit near the top of the 4 KiB register window.

The block sits on a simple 32-bit register bus with select, enable and write qualifiers. A separate size input tells full-word accesses apart from narrower ones. Writes take effect at the clock edge that ends the enable phase. Reads are combinational while the block is selected.

Top module: `rtc_seconds_match`

## Requirements
- R1: After reset, the seconds count, match value, restart snapshot and alarm flag are zero, and irqPulse is low.
- R2: With the prescaler set to N clock cycles, the seconds count rises by exactly one every N cycles. The first tick after a load comes N cycles after the loading edge.
- R3: A word read of offset 0x00 returns the seconds count. Writes to 0x00 change nothing.
- R4: Offset 0x04 holds a full 32-bit match value, which word writes set and word reads return unchanged.
- R5: When the seconds count is updated, by a tick or by a load, to a value equal to the match value, the alarm flag sets. At that same edge irqPulse goes high for one cycle.
- R6: A word write of zero to offset 0x08 clears the alarm flag. A word write of any nonzero value sets the flag and pulses irqPulse for one cycle. If a set and a clear arrive in the same cycle, the set wins. The flag can drop only through a zero write.
- R7: A word read of offset 0x08 returns the alarm flag in bit 0, with bits 31:1 zero. irqLevel always equals that flag.
- R8: A word write to offset 0x0C loads the written value into the seconds count and restarts the prescaler phase. A word read of 0x0C returns zero.
- R9: Any word write to offset 0x10 captures the current seconds count. A word read of 0x10 returns the seconds count minus that capture, modulo 2^32.
- R10: A word read of offset 0xFE0 returns 0x00041030, and a word read of offset 0xFD8 returns 0x000FFFFF.
- R11: accSize encodes 0 for byte, 1 for halfword and 2 for word, and only accSize = 2 is honoured. Narrower writes change no state, and narrower reads return zero.
- R12: Word reads of any other offset return zero, and writes to other offsets change no state. prdata is zero whenever no read is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the prescaler source |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral selected for an access |
| penable | input | 1 | Enable phase of the access; writes commit at this edge |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte offset inside the register window |
| pwdata | input | 32 | Write data |
| accSize | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| prdata | output | 32 | Read data, combinational while a read is selected |
| irqLevel | output | 1 | Alarm flag |
| irqPulse | output | 1 | One-cycle pulse at every setting event |

## Verification
The bound checker watches the read decode on every cycle: status, identification, load and narrow reads must return their fixed or flag-derived values. It also watches the alarm bookkeeping. Every pulse must coincide with a set flag, every rise of the flag must carry a pulse, and every fall must follow a zero write to the status offset. What only the scenarios can show is time-dependent: tick spacing after a load, the match firing on the exact tick or load, and the wraparound of the relative counter. They also show that ignored writes, namely data-offset, unmapped and narrow writes, leave every readable register untouched.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [11:0] OFS_SECONDS = 12'h000;
  localparam logic [11:0] OFS_MATCH   = 12'h004;
  localparam logic [11:0] OFS_STATUS  = 12'h008;
  localparam logic [11:0] OFS_LOAD    = 12'h00C;
  localparam logic [11:0] OFS_REL     = 12'h010;
  localparam logic [11:0] OFS_MASKW   = 12'hFD8;
  localparam logic [11:0] OFS_IDW     = 12'hFE0;

  localparam logic [31:0] ID_WORD   = 32'h0004_1030;
  localparam logic [31:0] MASK_WORD = 32'h000F_FFFF;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef struct packed {
    logic wrMatch;
    logic wrStatus;
    logic wrLoad;
    logic wrRestart;
  } rtcStrobes_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SECONDS,
    RD_MATCH,
    RD_STATUS,
    RD_REL,
    RD_IDW,
    RD_MASKW
  } rdSel_t;

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [1:0]        accSize,
  output rtcStrobes_t       strobes,
  output rdSel_t            rdSel
);

  logic wordWrite;
  logic wordRead;
  logic [11:0] ofs;

  generate
    if (ADDR_W >= 12) begin : g_wide
      assign ofs = paddr[11:0];
      if (ADDR_W > 12) begin : g_hi
        logic hiZero;
        assign hiZero = (paddr[ADDR_W-1:12] == '0);
        assign wordWrite = psel && penable && pwrite && (accSize == SIZE_WORD) && hiZero;
        assign wordRead  = psel && !pwrite && (accSize == SIZE_WORD) && hiZero;
      end else begin : g_exact
        assign wordWrite = psel && penable && pwrite && (accSize == SIZE_WORD);
        assign wordRead  = psel && !pwrite && (accSize == SIZE_WORD);
      end
    end else begin : g_narrow
      assign ofs = {{(12 - ADDR_W){1'b0}}, paddr};
      assign wordWrite = psel && penable && pwrite && (accSize == SIZE_WORD);
      assign wordRead  = psel && !pwrite && (accSize == SIZE_WORD);
    end
  endgenerate

  always_comb begin
    strobes = '0;
    if (wordWrite) begin
      unique case (ofs)
        OFS_MATCH:  strobes.wrMatch   = 1'b1;
        OFS_STATUS: strobes.wrStatus  = 1'b1;
        OFS_LOAD:   strobes.wrLoad    = 1'b1;
        OFS_REL:    strobes.wrRestart = 1'b1;
        default:    strobes = '0;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (wordRead) begin
      unique case (ofs)
        OFS_SECONDS: rdSel = RD_SECONDS;
        OFS_MATCH:   rdSel = RD_MATCH;
        OFS_STATUS:  rdSel = RD_STATUS;
        OFS_REL:     rdSel = RD_REL;
        OFS_IDW:     rdSel = RD_IDW;
        OFS_MASKW:   rdSel = RD_MASKW;
        default:     rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICK_CYCLES = 125_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  output logic tick
);

  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] phase;

  assign tick = (phase == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (!rstN || restart || phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  rtcStrobes_t       strobes,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqLevel,
  output logic              irqPulse
);

  logic [DATA_W-1:0] secCount;
  logic [DATA_W-1:0] matchVal;
  logic [DATA_W-1:0] snapVal;
  logic [DATA_W-1:0] secNext;
  logic              secUpdate;
  logic              matchHit;
  logic              setReq;
  logic              clrReq;
  logic              alarmFlag;
  logic              pulseQ;

  always_comb begin
    secNext   = secCount;
    secUpdate = 1'b0;
    if (strobes.wrLoad) begin
      secNext   = wdata;
      secUpdate = 1'b1;
    end else if (tick) begin
      secNext   = secCount + 1'b1;
      secUpdate = 1'b1;
    end
  end

  assign matchHit = secUpdate && (secNext == matchVal);
  assign setReq   = matchHit || (strobes.wrStatus && (wdata != '0));
  assign clrReq   = strobes.wrStatus && (wdata == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCount  <= '0;
      matchVal  <= '0;
      snapVal   <= '0;
      alarmFlag <= 1'b0;
      pulseQ    <= 1'b0;
    end else begin
      secCount <= secNext;
      if (strobes.wrMatch)   matchVal <= wdata;
      if (strobes.wrRestart) snapVal  <= secCount;
      if (setReq)            alarmFlag <= 1'b1;
      else if (clrReq)       alarmFlag <= 1'b0;
      pulseQ <= setReq;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_SECONDS: rdata = secCount;
      RD_MATCH:   rdata = matchVal;
      RD_STATUS:  rdata = {{(DATA_W - 1){1'b0}}, alarmFlag};
      RD_REL:     rdata = secCount - snapVal;
      RD_IDW:     rdata = DATA_W'(ID_WORD);
      RD_MASKW:   rdata = DATA_W'(MASK_WORD);
      default:    rdata = '0;
    endcase
  end

  assign irqLevel = alarmFlag;
  assign irqPulse = pulseQ;

endmodule

// File: rtl/rtc_seconds_match.sv
module rtc_seconds_match
  import rtc_pkg::*;
#(
  parameter int TICK_CYCLES = 125_000_000,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic [1:0]        accSize,
  output logic [31:0]       prdata,
  output logic              irqLevel,
  output logic              irqPulse
);

  rtcStrobes_t strobes;
  rdSel_t      rdSel;
  logic        tick;

  rtc_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .accSize (accSize),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  rtc_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) i_tick (
    .clk     (clk),
    .rstN    (rstN),
    .restart (strobes.wrLoad),
    .tick    (tick)
  );

  rtc_datapath #(.DATA_W(32)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .wdata    (pwdata),
    .rdata    (prdata),
    .irqLevel (irqLevel),
    .irqPulse (irqPulse)
  );

endmodule

// File: rtl/rtc_seconds_match_chk.sv
module rtc_seconds_match_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [1:0]        accSize,
  input logic [31:0]       prdata,
  input logic              irqLevel,
  input logic              irqPulse
);

  logic wordRd;
  logic wordWr;
  logic knownOfs;

  assign wordRd = psel && !pwrite && (accSize == 2'd2);
  assign wordWr = psel && penable && pwrite && (accSize == 2'd2);
  assign knownOfs = (paddr == ADDR_W'(12'h000)) || (paddr == ADDR_W'(12'h004)) ||
                    (paddr == ADDR_W'(12'h008)) || (paddr == ADDR_W'(12'h010)) ||
                    (paddr == ADDR_W'(12'hFD8)) || (paddr == ADDR_W'(12'hFE0));

  a_r6_pulse_has_level: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> irqLevel);

  a_r6_rise_has_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLevel) |-> irqPulse);

  a_r6_fall_needs_zero_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqLevel) |-> $past(wordWr && paddr == ADDR_W'(12'h008) && pwdata == 32'd0));

  a_r7_status_read: assert property (@(posedge clk) disable iff (!rstN)
    (wordRd && paddr == ADDR_W'(12'h008)) |-> (prdata == {31'd0, irqLevel}));

  a_r8_load_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wordRd && paddr == ADDR_W'(12'h00C)) |-> (prdata == 32'd0));

  a_r10_id_word: assert property (@(posedge clk) disable iff (!rstN)
    (wordRd && paddr == ADDR_W'(12'hFE0)) |-> (prdata == 32'h0004_1030));

  a_r10_mask_word: assert property (@(posedge clk) disable iff (!rstN)
    (wordRd && paddr == ADDR_W'(12'hFD8)) |-> (prdata == 32'h000F_FFFF));

  a_r11_narrow_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !pwrite && accSize != 2'd2) |-> (prdata == 32'd0));

  a_r12_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wordRd && !knownOfs) |-> (prdata == 32'd0));

endmodule

bind rtc_seconds_match rtc_seconds_match_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .accSize  (accSize),
  .prdata   (prdata),
  .irqLevel (irqLevel),
  .irqPulse (irqPulse)
);

// File: tb/test_rtc_seconds_match.sv
`timescale 1ns/1ps
module test_rtc_seconds_match;

  localparam int TICKS = 10;
  localparam int AW    = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          psel = 1'b0;
  logic          penable = 1'b0;
  logic          pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [1:0]    accSize = 2'd2;
  logic [31:0]   prdata;
  logic          irqLevel;
  logic          irqPulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       reqQ[$];

  always #4 clk = ~clk;

  rtc_seconds_match #(.TICK_CYCLES(TICKS), .ADDR_W(AW)) i_rtc_seconds_match (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .accSize(accSize), .prdata(prdata),
    .irqLevel(irqLevel), .irqPulse(irqPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data when a read reaches its enable phase
  always @(negedge clk) begin
    #2;
    if (psel && penable && !pwrite && expQ.size() > 0) begin
      logic [31:0] e;
      string r;
      e = expQ.pop_front();
      r = reqQ.pop_front();
      check(r, prdata, e);
    end
  end

  // all bus tasks start and end at a falling edge
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d; accSize = sz;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; accSize = 2'd2;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [1:0] sz,
                         input logic [31:0] exp, input string req);
    expQ.push_back(exp);
    reqQ.push_back(req);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a; accSize = sz;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; accSize = 2'd2;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, read before the first tick
    check("R1 irqLevel", {31'd0, irqLevel}, 32'd0);
    check("R1 irqPulse", {31'd0, irqPulse}, 32'd0);
    busRead(12'h000, 2'd2, 32'd0, "R1 seconds");
    busRead(12'h004, 2'd2, 32'd0, "R1 match");
    busRead(12'h008, 2'd2, 32'd0, "R1 status");
    busRead(12'h010, 2'd2, 32'd0, "R1 relative");

    // R4: match storage, park it far away
    busWrite(12'h004, 32'hA5C3_0F91, 2'd2);
    busRead(12'h004, 2'd2, 32'hA5C3_0F91, "R4 match readback");
    busWrite(12'h004, 32'hFFFF_0000, 2'd2);

    // R8 / R2: load then tick spacing
    busWrite(12'h00C, 32'd500, 2'd2);
    busRead(12'h000, 2'd2, 32'd500, "R8 load value");
    repeat (6) @(negedge clk);
    busRead(12'h000, 2'd2, 32'd500, "R2 before tick");
    busRead(12'h000, 2'd2, 32'd501, "R2 after tick");
    busRead(12'h00C, 2'd2, 32'd0, "R8 load reads zero");

    // R3: data offset write ignored
    busWrite(12'h00C, 32'd77, 2'd2);
    busWrite(12'h000, 32'hDEAD_BEEF, 2'd2);
    busRead(12'h000, 2'd2, 32'd77, "R3 data write ignored");

    // R10: identification words
    busRead(12'hFE0, 2'd2, 32'h0004_1030, "R10 id");
    busRead(12'hFD8, 2'd2, 32'h000F_FFFF, "R10 mask");

    // R12: unmapped offsets
    busRead(12'h014, 2'd2, 32'd0, "R12 unmapped read");
    busWrite(12'h014, 32'h1234_5678, 2'd2);
    busRead(12'h004, 2'd2, 32'hFFFF_0000, "R12 unmapped write ignored");

    // R11: narrow accesses
    busRead(12'h004, 2'd1, 32'd0, "R11 narrow read");
    busWrite(12'h004, 32'h0000_0001, 2'd0);
    busRead(12'h004, 2'd2, 32'hFFFF_0000, "R11 narrow write ignored");
    busWrite(12'h008, 32'd1, 2'd1);
    check("R11 narrow status write irqLevel", {31'd0, irqLevel}, 32'd0);
    busRead(12'h008, 2'd2, 32'd0, "R11 narrow status write");

    // R6 / R7: software set and clear
    busWrite(12'h008, 32'd5, 2'd2);
    check("R6 set pulse", {31'd0, irqPulse}, 32'd1);
    check("R6 set level", {31'd0, irqLevel}, 32'd1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, irqPulse}, 32'd0);
    busRead(12'h008, 2'd2, 32'd1, "R7 status set");
    busWrite(12'h008, 32'd0, 2'd2);
    check("R6 clear level", {31'd0, irqLevel}, 32'd0);
    check("R6 clear no pulse", {31'd0, irqPulse}, 32'd0);
    busRead(12'h008, 2'd2, 32'd0, "R7 status clear");

    // R5: match on a tick
    busWrite(12'h004, 32'd100, 2'd2);
    busWrite(12'h00C, 32'd99, 2'd2);
    check("R5 no early alarm", {31'd0, irqLevel}, 32'd0);
    repeat (9) @(negedge clk);
    check("R5 pulse before tick", {31'd0, irqPulse}, 32'd0);
    @(negedge clk);
    check("R5 tick pulse", {31'd0, irqPulse}, 32'd1);
    check("R5 tick level", {31'd0, irqLevel}, 32'd1);
    @(negedge clk);
    check("R5 tick pulse ends", {31'd0, irqPulse}, 32'd0);
    check("R5 level holds", {31'd0, irqLevel}, 32'd1);

    // R5: match on a load
    busWrite(12'h008, 32'd0, 2'd2);
    busWrite(12'h00C, 32'd100, 2'd2);
    check("R5 load pulse", {31'd0, irqPulse}, 32'd1);
    check("R5 load level", {31'd0, irqLevel}, 32'd1);
    busWrite(12'h008, 32'd0, 2'd2);
    busWrite(12'h004, 32'hFFFF_0000, 2'd2);

    // R9: relative counter and wraparound
    busWrite(12'h00C, 32'd1000, 2'd2);
    busWrite(12'h010, 32'h0, 2'd2);
    busRead(12'h010, 2'd2, 32'd0, "R9 relative zero");
    busWrite(12'h00C, 32'd5, 2'd2);
    busRead(12'h010, 2'd2, 32'hFFFF_FC1D, "R9 relative wrap");
    repeat (8) @(negedge clk);
    busRead(12'h010, 2'd2, 32'hFFFF_FC1E, "R9 relative after tick");

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule